// File: doc/BRIEF.md
# Flash Erase and Page-Program Engine

This block is the write side of a serial flash emulator. Its backing memory holds each stored word with the bits grouped by bit position, so the memory cannot mask a single byte on a write. An SPI front end decodes the incoming bytes and hands the engine an opcode strobe, an address strobe and data-byte strobes. The engine also watches the raw chip-select line, which it synchronises to its own clock.

When chip select rises after a complete command, the engine starts the command in the background. A page program collects the data bytes in a 256-byte page buffer. It then walks the whole page by read-modify-write: it reads every byte, ANDs in the collected data where a byte arrived, and writes every byte back. A sector erase writes 0xFF across an aligned 4 KB sector. The host learns that an operation has finished only by polling a status byte, which the engine drives at all times.

Top module: `flash_wr_engine`

## Requirements
- R1: The status output carries busy in bit 0 and the write-enable latch in bit 1, and bits 7..2 are always 0. Both bits are 0 after reset.
- R2: Opcode 0x06 (write enable) sets the write-enable latch when synchronised chip select rises, provided no operation is in progress.
- R3: Page program (0x02) and sector erase (0x20) issued while the write-enable latch is clear cause no memory write and leave the status at 0.
- R4: A page program that received at least one data byte stores each byte at the page base (address bits 23..8) plus an offset. The offset starts at address bits 7..0 and rises by one per byte, wrapping within the page. The stored value is the old byte AND the received byte. Bytes with no data keep their old value. The whole page is rewritten, giving exactly 256 memory writes.
- R5: When more than 256 data bytes arrive, only the last byte received for each offset is used.
- R6: A page program with an address but no data byte starts nothing: there is no memory write, and the write-enable latch stays set.
- R7: A sector erase writes 0xFF to all 4096 bytes of the sector selected by address bits 23..12, giving exactly 4096 writes, and changes nothing outside that sector.
- R8: Busy goes high when an accepted program or erase starts. When the operation completes, busy and the write-enable latch both return to 0. No memory request is made while busy is low.
- R9: Any command framed while busy is high, including write enable, is ignored. The status output keeps reporting busy throughout.
- R10: An operation starts only on the synchronised rising edge of chip select. Busy stays low while chip select is still low after all bytes have arrived.
- R11: A memory request, with its address and write flag, is held steady until the memory acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Raw SPI chip select, active low, asynchronous |
| cmd_stb | input | 1 | Opcode byte valid |
| cmd_op | input | 8 | Opcode byte |
| addr_stb | input | 1 | Address valid |
| addr | input | ADDR_W | Received address |
| data_stb | input | 1 | Data byte valid |
| data | input | 8 | Data byte |
| status | output | 8 | Status byte (bit 0 busy, bit 1 write enable) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 8 | Read data |

## Verification
The bench programs a run that starts eight bytes before the end of a page and wraps to the page start. A design that ran on into the next page would corrupt a neighbouring page, and the bench's full-memory comparison would show it. It sends 300 bytes so that some offsets are written twice; a design that ANDed every copy instead of keeping the last one would store bits that are too low. It also sends a program with no data, a program while the latch is clear, and a write enable during an erase. A design that mishandled these would rewrite a page, start without permission, or leave the latch set after completion. It checks the status before chip select rises, which catches a design that starts on the last data strobe rather than on the synchronised edge.

// File: rtl/flash_wr_engine.sv
module flash_wr_engine #(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_op,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data_stb,
  input  logic [7:0]        data,
  output logic [7:0]        status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);
  localparam int PAGE = 1 << PAGE_W;
  localparam logic [7:0] OP_WREN = 8'h06, OP_PROG = 8'h02, OP_ERASE = 8'h20;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_ER} state_t;
  state_t state;

  logic [1:0] cs_sync;
  logic cs_s, cs_d, cs_rise, cs_fall;
  assign cs_s    = cs_sync[1];
  assign cs_rise = cs_s & ~cs_d;
  assign cs_fall = ~cs_s & cs_d;

  logic live, op_seen, addr_seen, got_data, wel;
  logic [7:0] op_r;
  logic [ADDR_W-1:0] addr_r, base;
  logic [PAGE_W-1:0] wptr;
  logic [SECT_W-1:0] idx;
  logic [7:0] rbyte;
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pvld;

  wire busy = (state != S_IDLE);
  wire take_data = live && addr_seen && (op_r == OP_PROG) && data_stb;
  wire [PAGE_W-1:0] poff = idx[PAGE_W-1:0];

  assign status    = {6'b0, wel, busy};
  assign mem_req   = busy;
  assign mem_we    = (state == S_WR) || (state == S_ER);
  assign mem_addr  = base | ADDR_W'(idx);
  assign mem_wdata = (state == S_ER) ? 8'hFF : (pvld[poff] ? (rbyte & pbuf[poff]) : rbyte);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sync <= 2'b11;
      cs_d    <= 1'b1;
    end else begin
      cs_sync <= {cs_sync[0], cs_n};
      cs_d    <= cs_s;
    end

  always_ff @(posedge clk)
    if (take_data) pbuf[wptr] <= data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      live <= 1'b0; op_seen <= 1'b0; addr_seen <= 1'b0; got_data <= 1'b0;
      wel <= 1'b0; op_r <= '0; addr_r <= '0; base <= '0; wptr <= '0;
      idx <= '0; rbyte <= '0; pvld <= '0;
    end else begin
      if (cs_fall) begin
        live <= !busy;
        op_seen <= 1'b0; addr_seen <= 1'b0; got_data <= 1'b0;
        if (!busy) pvld <= '0;
      end
      if (live && !cs_s) begin
        if (cmd_stb && !op_seen) begin
          op_r <= cmd_op;
          op_seen <= 1'b1;
        end
        if (addr_stb && op_seen) begin
          addr_r <= addr;
          addr_seen <= 1'b1;
          wptr <= addr[PAGE_W-1:0];
        end
        if (take_data) begin
          pvld[wptr] <= 1'b1;
          wptr <= wptr + 1'b1;
          got_data <= 1'b1;
        end
      end
      if (cs_rise && live) begin
        live <= 1'b0;
        if (op_seen && op_r == OP_WREN) wel <= 1'b1;
        if (op_seen && op_r == OP_PROG && wel && addr_seen && got_data) begin
          base  <= {addr_r[ADDR_W-1:PAGE_W], PAGE_W'(0)};
          idx   <= '0;
          state <= S_RD;
        end
        if (op_seen && op_r == OP_ERASE && wel && addr_seen) begin
          base  <= {addr_r[ADDR_W-1:SECT_W], SECT_W'(0)};
          idx   <= '0;
          state <= S_ER;
        end
      end
      case (state)
        S_RD: if (mem_ack) begin
          rbyte <= mem_rdata;
          state <= S_WR;
        end
        S_WR: if (mem_ack) begin
          if (poff == PAGE_W'(PAGE - 1)) begin
            state <= S_IDLE;
            wel <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
            state <= S_RD;
          end
        end
        S_ER: if (mem_ack) begin
          if (&idx) begin
            state <= S_IDLE;
            wel <= 1'b0;
          end else idx <= idx + 1'b1;
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/flash_wr_engine_chk.sv
module flash_wr_engine_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic [7:0]        status,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(status[1]));

  p_done_clears_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> !mem_req);

  p_start_on_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (cs_n && $past(cs_n)));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_status_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |=> (status[0] || !status[1]) && (status[7:2] == 6'b0));
endmodule

bind flash_wr_engine flash_wr_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .status(status), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sim_flash_wr_engine.sv
`timescale 1ns/1ps
module sim_flash_wr_engine;
  localparam int MEMN = 8192;
  logic clk = 0, rst_n = 0, cs_n = 1;
  logic cmd_stb = 0, addr_stb = 0, data_stb = 0;
  logic [7:0] cmd_op = 0, data = 0;
  logic [23:0] addr = 0;
  logic [7:0] status;
  logic mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  flash_wr_engine u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .addr_stb(addr_stb), .addr(addr), .data_stb(data_stb), .data(data), .status(status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [7:0] mem [MEMN];
  logic [7:0] ref_m [MEMN];
  int wcnt;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= 8'(i * 29 + 7);
      mem_ack <= 0; mem_rdata <= 0; wcnt <= 0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1;
      if (mem_we) begin
        mem[mem_addr[12:0]] <= mem_wdata;
        wcnt <= wcnt + 1;
      end else mem_rdata <= mem[mem_addr[12:0]];
    end else mem_ack <= 0;

  int total = 0, fails = 0;
  logic [7:0] dbuf [512];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = -1;
    for (int i = 0; i < MEMN; i++) if (bad < 0 && mem[i] !== ref_m[i]) bad = i;
    if (bad < 0) chk(1, tag, 0, 0);
    else chk(0, {tag, " mem mismatch"}, int'(mem[bad]), int'(ref_m[bad]));
  endtask

  task automatic send(input [7:0] op, input bit has_addr, input [23:0] a, input int n,
                      input string tag, input bit check_low);
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    cmd_stb = 1; cmd_op = op;
    @(negedge clk) cmd_stb = 0;
    if (has_addr) begin
      addr_stb = 1; addr = a;
      @(negedge clk) addr_stb = 0;
    end
    for (int k = 0; k < n; k++) begin
      data_stb = 1; data = dbuf[k];
      @(negedge clk);
    end
    data_stb = 0;
    repeat (3) @(negedge clk);
    if (check_low) chk(status[0] == 0, {tag, " R10 busy before cs rise"}, status, 0);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (status[0] && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, {tag, " R8 completion"}, t, 0);
  endtask

  // entry: page[4:0], start[7:0], count[9:0], seed[7:0]
  localparam logic [30:0] VEC [6] = '{
    {5'd3,  8'h00, 10'd1,   8'hA5},
    {5'd5,  8'h10, 10'd16,  8'h3C},
    {5'd7,  8'hF8, 10'd16,  8'h77},
    {5'd2,  8'h00, 10'd256, 8'h0F},
    {5'd9,  8'h80, 10'd300, 8'hE1},
    {5'd3,  8'h00, 10'd1,   8'h5A}
  };

  task automatic ref_prog(input int page, input int start, input int cnt);
    logic [7:0] pb [256];
    bit v [256];
    for (int i = 0; i < 256; i++) v[i] = 0;
    for (int k = 0; k < cnt; k++) begin
      pb[(start + k) % 256] = dbuf[k];
      v[(start + k) % 256] = 1;
    end
    for (int i = 0; i < 256; i++)
      if (v[i]) ref_m[page * 256 + i] = ref_m[page * 256 + i] & pb[i];
  endtask

  initial begin
    int w0;
    for (int i = 0; i < MEMN; i++) ref_m[i] = 8'(i * 29 + 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 8'h00, "R1 reset status", status, 0);

    // R3: program without write enable
    dbuf[0] = 8'h00;
    w0 = wcnt;
    send(8'h02, 1, 24'h000300, 1, "R3", 0);
    chk(status == 8'h00, "R3 status without WEL", status, 0);
    chk(wcnt == w0, "R3 no writes", wcnt - w0, 0);
    send(8'h20, 1, 24'h000000, 0, "R3", 0);
    chk(wcnt == w0 && status == 0, "R3 erase without WEL", wcnt - w0, 0);
    cmp_mem("R3");

    // R6: program with address but no data
    send(8'h06, 0, 0, 0, "R2", 0);
    chk(status == 8'h02, "R2 WEL set", status, 2);
    send(8'h02, 1, 24'h000400, 0, "R6", 0);
    chk(status == 8'h02, "R6 no start, WEL kept", status, 2);
    chk(wcnt == w0, "R6 no writes", wcnt - w0, 0);

    // Table of program vectors: R4, R5
    foreach (VEC[e]) begin
      int pg = int'(VEC[e][30:26]);
      int st = int'(VEC[e][25:18]);
      int cn = int'(VEC[e][17:8]);
      logic [7:0] sd = VEC[e][7:0];
      for (int k = 0; k < cn; k++) dbuf[k] = sd ^ 8'(k * 13);
      if (e > 0) send(8'h06, 0, 0, 0, "R2", 0);
      chk(status == 8'h02, "R2 WEL before program", status, 2);
      w0 = wcnt;
      send(8'h02, 1, 24'(pg * 256 + st), cn, "R4", 1);
      chk(status[0] == 1, "R8 busy after start", status, 1);
      wait_idle("R4");
      chk(status == 8'h00, "R8 busy and WEL clear at end", status, 0);
      chk(wcnt - w0 == 256, "R4 whole page written", wcnt - w0, 256);
      ref_prog(pg, st, cn);
      cmp_mem(cn > 256 ? "R5 last byte wins" : "R4 merge and wrap");
    end

    // R7: sector erase
    send(8'h06, 0, 0, 0, "R2", 0);
    w0 = wcnt;
    send(8'h20, 1, 24'h001234, 0, "R7", 1);
    chk(status == 8'h03, "R8 busy with WEL during erase", status, 3);
    wait_idle("R7");
    chk(status == 8'h00, "R8 clear after erase", status, 0);
    chk(wcnt - w0 == 4096, "R7 write count", wcnt - w0, 4096);
    for (int i = 4096; i < 8192; i++) ref_m[i] = 8'hFF;
    cmp_mem("R7 erase");

    // R9: commands during busy ignored
    send(8'h06, 0, 0, 0, "R2", 0);
    send(8'h20, 1, 24'h000000, 0, "R9", 0);
    send(8'h06, 0, 0, 0, "R9", 0);
    chk(status == 8'h03, "R9 status readable while busy", status, 3);
    dbuf[0] = 8'h00;
    send(8'h02, 1, 24'h001000, 1, "R9", 0);
    chk(status[0] == 1, "R9 still busy", status, 1);
    wait_idle("R9");
    chk(status == 8'h00, "R9 ignored WREN left no latch", status, 0);
    for (int i = 0; i < 4096; i++) ref_m[i] = 8'hFF;
    cmp_mem("R9 ignored program");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule